// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block is a purely combinational binary adder of parameterised width. The width must be a multiple of 16 and defaults to 16. The operands are cut into 4-bit slices. Every slice works out its internal carries in lookahead form and reports whether it creates a carry on its own (group generate) and whether it would pass an incoming carry through (group propagate). A lookahead generator of the same form combines four slices at a time into a block. A second generator spans the blocks and hands each block its carry-in. No carry travels from one slice to the next along a chain.

A subtract control turns the adder into an A minus B unit. It inverts the second operand and forces the carry-in high, so the external carry-in has no effect while subtracting. Besides the sum and the carry-out, the block exposes the top-level group generate and group propagate. A wider adder can therefore be built by placing one more lookahead level above several instances of this block.

Top module: `cla_adder_tree`

## Requirements
- R1: With `subtract` = 0, `sum` equals (`opA` + `opB` + `carryIn`) modulo 2^WIDTH.
- R2: `carryOut` equals bit WIDTH of the unbounded sum of the effective operands and the effective carry-in.
- R3: With `subtract` = 1, `sum` equals (`opA` + ~`opB` + 1) modulo 2^WIDTH and `carryOut` is 1 exactly when `opA` >= `opB` as unsigned values. `carryIn` has no effect on any output in this mode.
- R4: `groupGen` is 1 exactly when `opA` plus the effective second operand, with a carry-in of zero, overflows WIDTH bits.
- R5: `groupProp` is 1 exactly when every bit position has `opA[i]` OR effective `opB[i]` equal to 1. Propagate is the OR form, not the XOR form.
- R6: `carryOut` always equals `groupGen` OR (`groupProp` AND effective carry-in). The effective carry-in is `carryIn` when adding and 1 when subtracting.
- R7: A carry created in any slice reaches every higher slice in the same evaluation. All ones plus one gives a zero sum with `carryOut` = 1.
- R8: Zero plus zero with `carryIn` = 1 gives `sum` = 1, `carryOut` = 0, `groupGen` = 0 and `groupProp` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand (subtrahend when subtracting) |
| carryIn | input | 1 | Carry into bit 0 when adding |
| subtract | input | 1 | 1 selects opA minus opB |
| sum | output | WIDTH | Result, modulo 2^WIDTH |
| carryOut | output | 1 | Carry out of the top bit |
| groupGen | output | 1 | Whole-word group generate |
| groupProp | output | 1 | Whole-word group propagate |

## Verification
The block holds no state, so any wrong internal signal shows up at the ports in the same evaluation as the operands that expose it. A bad slice generate or propagate term corrupts the sum nibbles above that slice. It does this only for operand patterns whose carry has to cross the faulty slice, so the directed tests place a carry at every slice and block boundary. A fault in the block-level generator shows up as a disagreement among `carryOut`, `groupGen` and `groupProp`, which the bench cross-checks against each other and against a plain wide addition.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // generate / propagate pair describing a bit or a group of bits
  typedef struct packed {
    logic gen;
    logic prop;
  } grp_t;

  // strobes from operand control to the datapath
  typedef struct packed {
    logic invB;    // complement the second operand
    logic cinOne;  // force carry-in high
  } ctl_t;

endpackage

// File: rtl/cla_lookahead_gen.sv
// Fully expanded lookahead generator over WAYS members: every carry is a
// sum of products of member terms and cin, so no carry feeds another.
module cla_lookahead_gen
  import cla_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  grp_t [WAYS-1:0] members,
  input  logic            cin,
  output logic [WAYS:0]   carries,  // carries[k] enters member k; [WAYS] leaves
  output grp_t            total
);

  always_comb begin
    for (int k = 0; k <= WAYS; k++) begin
      logic c;
      c = cin;
      for (int m = 0; m < k; m++) c = c & members[m].prop;
      for (int j = 0; j < k; j++) begin
        logic term;
        term = members[j].gen;
        for (int m = j + 1; m < k; m++) term = term & members[m].prop;
        c = c | term;
      end
      carries[k] = c;
    end
  end

  always_comb begin
    logic g;
    logic p;
    g = 1'b0;
    p = 1'b1;
    for (int j = 0; j < WAYS; j++) begin
      logic term;
      term = members[j].gen;
      for (int m = j + 1; m < WAYS; m++) term = term & members[m].prop;
      g = g | term;
      p = p & members[j].prop;
    end
    total.gen  = g;
    total.prop = p;
  end

  // carry-out of the group agrees with the group summary terms
  always_comb begin
    assert_gen_out_R6: assert (carries[WAYS] == (total.gen | (total.prop & cin)))
      else $error("group carry-out disagrees with group generate/propagate");
  end

  // nothing generated and no carry-in: no carry anywhere
  always_comb begin
    logic anyGen;
    anyGen = 1'b0;
    for (int j = 0; j < WAYS; j++) anyGen = anyGen | members[j].gen;
    if (!anyGen && !cin) begin
      assert_gen_quiet_R6: assert ($countones(carries) == 0)
        else $error("carry appeared with no generate and no carry-in");
    end
  end

endmodule

// File: rtl/cla_slice4.sv
// 4-bit lookahead slice: bit generate/propagate fed to a 4-way generator.
module cla_slice4
  import cla_pkg::*;
(
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] sum,
  output grp_t       grp
);

  grp_t [3:0] bitGp;
  logic [4:0] bitCarry;

  for (genvar i = 0; i < 4; i++) begin : g_bit
    assign bitGp[i].gen  = a[i] & b[i];
    assign bitGp[i].prop = a[i] | b[i];
    assign sum[i]        = a[i] ^ b[i] ^ bitCarry[i];
  end

  cla_lookahead_gen #(.WAYS(4)) u_bitGen (
    .members (bitGp),
    .cin     (cin),
    .carries (bitCarry),
    .total   (grp)
  );

  always_comb begin
    assert_slice_sum_R1: assert ({bitCarry[4], sum} == (5'(a) + 5'(b) + 5'(cin)))
      else $error("slice result differs from 4-bit addition");
  end

endmodule

// File: rtl/cla_operand_ctl.sv
// Operand control: turns the subtract request into datapath strobes.
module cla_operand_ctl
  import cla_pkg::*;
(
  input  logic subtract,
  output ctl_t ctl
);

  assign ctl.invB   = subtract;
  assign ctl.cinOne = subtract;

endmodule

// File: rtl/cla_datapath.sv
// Slices, block-level generators and the word-level generator.
module cla_datapath
  import cla_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  ctl_t             ctl,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output grp_t             topGrp
);

  localparam int SLICES = WIDTH / 4;
  localparam int BLOCKS = WIDTH / 16;

  logic [WIDTH-1:0]        bEff;
  logic                    cinEff;
  grp_t [SLICES-1:0]       sliceGrp;
  logic [SLICES-1:0]       sliceCin;
  grp_t [BLOCKS-1:0]       blockGrp;
  logic [BLOCKS-1:0][4:0]  blockCarries;
  logic [BLOCKS:0]         wordCarries;

  assign bEff   = ctl.invB ? ~opB : opB;
  assign cinEff = ctl.cinOne ? 1'b1 : carryIn;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    cla_slice4 u_slice (
      .a   (opA[4*s +: 4]),
      .b   (bEff[4*s +: 4]),
      .cin (sliceCin[s]),
      .sum (sum[4*s +: 4]),
      .grp (sliceGrp[s])
    );
  end

  for (genvar k = 0; k < BLOCKS; k++) begin : g_block
    cla_lookahead_gen #(.WAYS(4)) u_blockGen (
      .members (sliceGrp[4*k +: 4]),
      .cin     (wordCarries[k]),
      .carries (blockCarries[k]),
      .total   (blockGrp[k])
    );
    assign sliceCin[4*k +: 4] = blockCarries[k][3:0];

    // block carry-out seen by the word level matches the block's own view
    always_comb begin
      assert_block_carry_R7: assert (blockCarries[k][4] == wordCarries[k+1])
        else $error("block carry-out differs between levels");
    end
  end

  cla_lookahead_gen #(.WAYS(BLOCKS)) u_wordGen (
    .members (blockGrp),
    .cin     (cinEff),
    .carries (wordCarries),
    .total   (topGrp)
  );

  assign carryOut = wordCarries[BLOCKS];

  always_comb begin
    assert_word_add_R2: assert ({carryOut, sum} ==
        ((WIDTH+1)'(opA) + (WIDTH+1)'(bEff) + (WIDTH+1)'(cinEff)))
      else $error("word result differs from wide addition");
  end

  always_comb begin
    if (ctl.invB) begin
      assert_sub_cin_R3: assert (cinEff == 1'b1 && bEff == ~opB)
        else $error("subtract did not complement operand or force carry");
    end
  end

endmodule

// File: rtl/cla_adder_tree.sv
module cla_adder_tree
  import cla_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             groupGen,
  output logic             groupProp
);

  ctl_t ctl;
  grp_t topGrp;

  cla_operand_ctl u_ctl (
    .subtract (subtract),
    .ctl      (ctl)
  );

  cla_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .ctl      (ctl),
    .sum      (sum),
    .carryOut (carryOut),
    .topGrp   (topGrp)
  );

  assign groupGen  = topGrp.gen;
  assign groupProp = topGrp.prop;

  initial begin
    assert_width_R1: assert (WIDTH >= 16 && WIDTH % 16 == 0)
      else $error("WIDTH must be a non-zero multiple of 16");
  end

endmodule

// File: tb/sim_cla_adder_tree.sv
module sim_cla_adder_tree;

  localparam int W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] opA, opB, sum;
  logic carryIn, subtract, carryOut, groupGen, groupProp;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  cla_adder_tree #(.WIDTH(W)) u0 (
    .opA(opA), .opB(opB), .carryIn(carryIn), .subtract(subtract),
    .sum(sum), .carryOut(carryOut), .groupGen(groupGen), .groupProp(groupProp)
  );

  task automatic chk(string req, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive after a rising edge, sample on the following falling edge
  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic ci, logic sb, string req);
    logic [W-1:0] be;
    logic         ce;
    logic [W:0]   full, noCin;
    @(posedge clk);
    opA = a; opB = b; carryIn = ci; subtract = sb;
    @(negedge clk);
    be    = sb ? ~b : b;
    ce    = sb ? 1'b1 : ci;
    full  = (W+1)'(a) + (W+1)'(be) + (W+1)'(ce);
    noCin = (W+1)'(a) + (W+1)'(be);
    chk({req, " sum"}, {1'b0, sum}, {1'b0, full[W-1:0]});
    chk("R2 carryOut", {{W{1'b0}}, carryOut}, {{W{1'b0}}, full[W]});
    chk("R4 groupGen", {{W{1'b0}}, groupGen}, {{W{1'b0}}, noCin[W]});
    chk("R5 groupProp", {{W{1'b0}}, groupProp}, {{W{1'b0}}, &(a | be)});
    chk("R6 carry relation", {{W{1'b0}}, carryOut},
        {{W{1'b0}}, groupGen | (groupProp & ce)});
  endtask

  task automatic test_idle;
    apply('0, '0, 1'b0, 1'b0, "R1 idle");
  endtask

  task automatic test_corners;
    apply('1, 16'h0001, 1'b0, 1'b0, "R7 ones+1");
    chk("R7 ones+1 zero sum", {carryOut, sum}, {1'b1, 16'h0000});
    apply('0, '0, 1'b1, 1'b0, "R8 zero+cin");
    chk("R8 zero+cin", {carryOut, sum}, {1'b0, 16'h0001});
    chk("R8 gen/prop low", {{W-1{1'b0}}, groupGen, groupProp}, '0);
    apply('1, '0, 1'b1, 1'b0, "R7 ones+cin");
    apply('1, '1, 1'b1, 1'b0, "R1 ones+ones+cin");
    apply(16'h5555, 16'hAAAA, 1'b0, 1'b0, "R5 alternating prop");
  endtask

  task automatic test_boundaries;
    for (int s = 0; s < W / 4; s++) begin
      logic [W-1:0] a;
      a = W'(16'h000F) << (4 * s);
      apply(a, W'(1) << (4 * s), 1'b0, 1'b0, "R7 slice carry");
      apply(~a, a, 1'b1, 1'b0, "R7 carry chain");
    end
  endtask

  task automatic test_random_add;
    for (int i = 0; i < 200; i++)
      apply(W'($urandom), W'($urandom), 1'($urandom), 1'b0, "R1 random add");
  endtask

  task automatic test_subtract;
    logic [W:0] first;
    apply(16'd9, 16'd3, 1'b0, 1'b1, "R3 9-3");
    chk("R3 9-3", {carryOut, sum}, {1'b1, 16'd6});
    apply(16'd3, 16'd9, 1'b0, 1'b1, "R3 3-9");
    chk("R3 3-9", {carryOut, sum}, {1'b0, 16'hFFFA});
    apply(16'h1234, 16'h1234, 1'b0, 1'b1, "R3 equal");
    chk("R3 equal", {carryOut, sum}, {1'b1, 16'h0000});
    for (int i = 0; i < 100; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      apply(a, b, 1'b0, 1'b1, "R3 random sub");
      first = {carryOut, sum};
      chk("R3 borrow flag", {{W{1'b0}}, carryOut}, {{W{1'b0}}, a >= b});
      apply(a, b, 1'b1, 1'b1, "R3 carryIn ignored");
      chk("R3 carryIn ignored", {carryOut, sum}, first);
    end
  endtask

  initial begin
    opA = '0; opB = '0; carryIn = 1'b0; subtract = 1'b0;
    test_idle();
    test_corners();
    test_boundaries();
    test_random_add();
    test_subtract();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule